// File: doc/BRIEF.md
# Grouped-Interrupt General-Purpose Pin Port

This block is a bank of general-purpose pins behind a small word-addressed register port. Each pin is either an output, driven from a stored value, or an input. An input passes through a two-flop synchronizer and an optional per-pin inverter before it is sampled. A direction register chooses the role of each pin. Software changes output pins through a full-value register or through bit-set and bit-clear registers, and bits that belong to input pins are never touched by these writes.

Each sampled input that goes from 0 to 1 latches a bit in a cause register. Pins are split into groups of eight. Each group drives one summary interrupt line, gated by a single shared mask register that is reachable at two addresses. A mode bit sets the summary source. In edge mode a line follows the masked cause bits, and software clears them by writing the cause register. In level mode a line follows the masked sampled input values directly, and cause writes are dropped.

Register accesses use plain control pins: one write or one read per cycle, with no stall. Read data is registered and appears the cycle after `rd_en`.

Top module: `gpio_grp_port`

## Requirements
- R1: After reset every register reads 0. Every pin is an input (`pin_oe` = 0), polarity is normal, every mask bit is 0 and `irq` is 0.
- R2: The address map is DIR=0, INV=1, VAL=2, SET=3, CLR=4, CAUSE=5, MASK=6 and 7, MODE=8. `pin_oe` equals DIR (1 = output). A write to VAL replaces only the bits whose DIR bit is 1. `pin_out` carries the VAL register.
- R3: A write to SET ORs the written bits into VAL, and a write to CLR removes them. In both cases only DIR=1 bits are affected, and both addresses read back as 0.
- R4: For input pins, VAL reads the synchronized input XOR the INV bit. This is visible three clock edges after `pin_in` changes.
- R5: A 0-to-1 change of a sampled input on a pin with DIR=0 sets that pin's CAUSE bit. Pins with DIR=1 never set CAUSE.
- R6: Addresses 6 and 7 access one shared mask register.
- R7: MODE reads as 0x11FF0000 with bit 10 showing the stored mode. Only bit 10 of a write is kept (1 = level mode).
- R8: In edge mode, `irq[g]` is the OR over group g (pins 8g..8g+7) of CAUSE AND MASK, registered. A CAUSE write replaces its contents, except that a rise in the same cycle still sets its bit. CAUSE bits are cleared in no other way.
- R9: In level mode, `irq[g]` is the OR over group g of (VAL AND MASK AND NOT DIR), registered, so the line drops once the masked inputs of the group fall to 0. CAUSE writes are ignored in this mode.
- R10: A group whose mask bits are all 0 never raises its `irq` line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables (DIR) |
| irq | output | 4 | Per-group summary interrupts |

## Verification
A register write takes effect at the clock edge that samples it. A read result is due on `rdata` one edge after `rd_en` is sampled. A `pin_in` change reaches VAL and CAUSE at the third edge and `irq` at the fourth. A mask, mode or cause write reaches `irq` one edge after it is applied.

The bench checks ports only at falling edges, after these counts have elapsed. A monitor matches each read against the next queued expectation on the falling edge after the read was sampled.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  typedef enum logic [3:0] {
    A_DIR    = 4'd0,
    A_INV    = 4'd1,
    A_VAL    = 4'd2,
    A_SET    = 4'd3,
    A_CLR    = 4'd4,
    A_CAUSE  = 4'd5,
    A_MASK_A = 4'd6,
    A_MASK_B = 4'd7,
    A_MODE   = 4'd8
  } reg_addr_e;

  localparam int unsigned MODE_BIT = 10;
  localparam logic [31:0] MODE_RB  = 32'h11FF_0000;
endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] inv,
  output logic [W-1:0] samp,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= samp;
    end
  end

  // polarity applies ahead of edge detection
  assign samp = s2_q ^ inv;
  assign rise = samp & ~prev_q;
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq #(
  parameter int unsigned GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level_mode,
  input  logic [GW-1:0] cause,
  input  logic [GW-1:0] lvl,
  input  logic [GW-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= level_mode ? |(lvl & mask) : |(cause & mask);
  end

  // R10: a fully masked group stays quiet
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/gpio_grp_port.sv
module gpio_grp_port
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned GW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [3:0]            addr,
  input  logic [NPINS-1:0]      wdata,
  output logic [NPINS-1:0]      rdata,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic [NPINS/GW-1:0]   irq
);
  localparam int unsigned NGRP = NPINS / GW;
  localparam logic [NPINS-1:0] MODE_CONST = NPINS'(MODE_RB);

  logic [NPINS-1:0] dir_q, inv_q, val_q, cause_q, mask_q;
  logic             mode_q;
  logic [NPINS-1:0] samp, rise, rise_in, out_d, val_d, cause_d, wmask;
  logic wr_dir, wr_inv, wr_val, wr_set, wr_clr, wr_cause, wr_mask, wr_mode;

  gpio_in_stage #(.W(NPINS)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .inv(inv_q),
    .samp(samp), .rise(rise)
  );

  assign wr_dir   = wr_en && (addr == A_DIR);
  assign wr_inv   = wr_en && (addr == A_INV);
  assign wr_val   = wr_en && (addr == A_VAL);
  assign wr_set   = wr_en && (addr == A_SET);
  assign wr_clr   = wr_en && (addr == A_CLR);
  assign wr_cause = wr_en && (addr == A_CAUSE);
  assign wr_mask  = wr_en && ((addr == A_MASK_A) || (addr == A_MASK_B));
  assign wr_mode  = wr_en && (addr == A_MODE);

  assign wmask   = wdata & dir_q;
  assign rise_in = rise & ~dir_q;

  always_comb begin
    out_d = val_q & dir_q;
    if (wr_val) out_d = wmask;
    if (wr_set) out_d = out_d | wmask;
    if (wr_clr) out_d = out_d & ~wmask;
    val_d = (out_d & dir_q) | (samp & ~dir_q);
  end

  always_comb begin
    cause_d = (wr_cause && !mode_q) ? wdata : cause_q;
    cause_d = cause_d | rise_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      inv_q   <= '0;
      val_q   <= '0;
      cause_q <= '0;
      mask_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_inv)  inv_q  <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_mode) mode_q <= wdata[MODE_BIT];
      val_q   <= val_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_DIR:              rdata <= dir_q;
        A_INV:              rdata <= inv_q;
        A_VAL:              rdata <= val_q;
        A_CAUSE:            rdata <= cause_q;
        A_MASK_A, A_MASK_B: rdata <= mask_q;
        A_MODE: begin
          rdata           <= MODE_CONST;
          rdata[MODE_BIT] <= mode_q;
        end
        default:            rdata <= '0;
      endcase
    end
  end

  assign pin_out = val_q;
  assign pin_oe  = dir_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gpio_group_irq #(.GW(GW)) u_grp (
      .clk(clk), .rst_n(rst_n), .level_mode(mode_q),
      .cause(cause_q[g*GW +: GW]),
      .lvl  (val_q[g*GW +: GW] & ~dir_q[g*GW +: GW]),
      .mask (mask_q[g*GW +: GW]),
      .irq  (irq[g])
    );
  end

  // R2: a full-value write lands only on output pins
  p_val_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> ((pin_out & $past(dir_q)) == ($past(wdata) & $past(dir_q))));

  // R3: set raises and clear lowers the addressed output pins
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(wmask)) == $past(wmask)));
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(wmask)) == '0));

  // R8/R9: cause bits only drop through an edge-mode cause write
  p_cause_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cause && !mode_q) |=> (($past(cause_q) & ~cause_q) == '0));

  // R7: the mode readback keeps its fixed upper pattern
  p_mode_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_MODE)) |=> (rdata[NPINS-1:MODE_BIT+1] == MODE_CONST[NPINS-1:MODE_BIT+1]));
endmodule

// File: tb/sim_gpio_grp_port.sv
module sim_gpio_grp_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_grp_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pop one expectation per completed read
  always @(negedge clk) begin
    if (rd_seen) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read result: got %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(pin_oe, 32'h0, "R1 pin_oe");
    chk({28'h0, irq}, 32'h0, "R1 irq");
    for (int a = 0; a < 8; a++) rd(4'(a), 32'h0, "R1 reg reset");
    rd(4'd8, 32'h11FF0000, "R1 mode reset");

    // R2 direction-gated value write
    wr(4'd0, 32'h0000FFFF);
    chk(pin_oe, 32'h0000FFFF, "R2 pin_oe");
    pin_in = 32'h0000_0001;            // output pin driven externally
    wr(4'd2, 32'hFFFFFFFF);
    chk(pin_out & pin_oe, 32'h0000FFFF, "R2 pin_out");
    idle(3);
    rd(4'd2, 32'h0000FFFF, "R2 value");

    // R3 set / clear
    wr(4'd4, 32'h00FF00FF);
    rd(4'd2, 32'h0000FF00, "R3 clear");
    rd(4'd4, 32'h0, "R3 clear reads 0");
    wr(4'd3, 32'hFF000003);
    rd(4'd2, 32'h0000FF03, "R3 set");
    rd(4'd3, 32'h0, "R3 set reads 0");

    // R4/R5 inversion creates rises on input pins 20..23
    wr(4'd1, 32'h00F00000);
    idle(3);
    rd(4'd2, 32'h00F0FF03, "R4 inverted input");
    rd(4'd5, 32'h00F00000, "R5 cause, output pins excluded");

    // R6 mask alias, R10 masked group, R8 edge summary
    chk({28'h0, irq}, 32'h0, "R10 all masked");
    wr(4'd7, 32'h00100000);
    rd(4'd6, 32'h00100000, "R6 mask alias");
    chk({28'h0, irq}, 32'h4, "R8 edge irq group2");
    wr(4'd5, 32'h00EF0000);
    idle(1);
    chk({28'h0, irq}, 32'h0, "R8 cause write clears");

    wr(4'd6, 32'h80100000);
    pin_in = 32'h8000_0001;
    idle(5);
    chk({28'h0, irq}, 32'h8, "R5 rise pin31 irq");
    rd(4'd5, 32'h80EF0000, "R5 cause pin31");
    pin_in = 32'h0000_0001;
    idle(5);
    chk({28'h0, irq}, 32'h8, "R8 latched after fall");

    // R7 mode register, R9 level behaviour
    wr(4'd8, 32'hFFFFFFFF);
    rd(4'd8, 32'h11FF0400, "R7 mode readback");
    chk({28'h0, irq}, 32'h4, "R9 level irq group2");
    wr(4'd5, 32'h0);
    rd(4'd5, 32'h80EF0000, "R9 cause write ignored");
    wr(4'd1, 32'h0);
    idle(4);
    chk({28'h0, irq}, 32'h0, "R9 level drops");
    rd(4'd2, 32'h0000FF03, "R4 polarity restored");

    wr(4'd8, 32'h0);
    rd(4'd8, 32'h11FF0000, "R7 mode cleared");
    chk({28'h0, irq}, 32'h8, "R8 edge source again");

    idle(2);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d reads missing, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule